// File: doc/BRIEF.md
# Shadow-Loaded Prescaled PWM Controller

A multi-channel pulse-width modulator that sits behind a small memory-mapped register port. Every channel divides the system clock by a programmable prescale factor and runs a period counter up to a programmable modulus. Its output stays high while that counter is below a programmable duty threshold.

Software writes the modulus first, then the duty value. The duty write is the single event that hands both numbers to the running channel. The hand-over waits for the period already in progress to finish, so no period is ever built from a mix of old and new settings. Clearing a channel's enable bit does not wait: the output drops and the channel's counters return to zero straight away.

Each channel owns a 32-byte register window. Reads are registered and return their data one clock after the read strobe.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: The byte address selects channel `addr[6:5]` and a word in that channel's 32-byte window through `addr[4:2]`. Word offset 0x0 is prescale (bits 7:0), 0x4 is modulus (bits 7:0), 0x8 is duty (bits 15:0) and 0x18 is enable (bit 0). `addr[1:0]` is ignored.
- R2: A read strobe places the addressed register's last written value on `rdata` after the next rising edge, with unused bits zero. `rdata` holds its value in cycles with no read strobe.
- R3: Each step of the period counter lasts prescale+1 clock cycles.
- R4: A period lasts (prescale+1) × modulus clock cycles. A modulus of 0 behaves like a modulus of 1.
- R5: An enabled channel's output is high while its period count is below the active duty value. A duty of at least the modulus gives a constant high, and a duty of 0 gives a constant low.
- R6: A modulus write is only staged. A duty write commits the staged modulus together with the new duty. The commit takes effect at the first period boundary at or after the write edge, and no period mixes old and new values.
- R7: Writing 0 to enable drives the output low from the write edge onward, without finishing the period, and returns the channel's counters to zero.
- R8: Writing 1 to enable starts a fresh period at count 0 using the latest committed settings. A commit made while the channel is disabled applies directly.
- R9: Offsets 0xC, 0x10, 0x14 and 0x1C read as zero, and writes to them change nothing.
- R10: Channels are independent. An access to one channel leaves the outputs and registers of the others unchanged.
- R11: The prescale register is sampled into the running channel only at period boundaries and while the channel is disabled.
- R12: After reset, all registers read zero, every output is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the counting source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 7 | Byte address (channel and word) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The hardest case to reach is a duty write that lands on the exact edge where the running period ends. In that case the new values must take effect with no delay and must not be held back for a further period. A second hard case is a commit still pending when the channel is disabled. To reach the first case, the stimulus issues duty writes after a sweep of idle gaps, stepping one cycle at a time across a whole prescaled period, so that some write falls on every phase of it, the boundary included. A behavioural reference model, compared with the outputs and the read data every cycle, decides the expected result for each of these cases.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CH_SHIFT = 5;
  localparam int WORD_W   = CH_SHIFT - 2;
  localparam logic [WORD_W-1:0] WORD_PRE  = 3'd0;
  localparam logic [WORD_W-1:0] WORD_MOD  = 3'd1;
  localparam logic [WORD_W-1:0] WORD_DUTY = 3'd2;
  localparam logic [WORD_W-1:0] WORD_EN   = 3'd6;
  localparam int DEF_PRE_W  = 8;
  localparam int DEF_MOD_W  = 8;
  localparam int DEF_DUTY_W = 16;
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PRE_W  = DEF_PRE_W,
  parameter int MOD_W  = DEF_MOD_W,
  parameter int DUTY_W = DEF_DUTY_W,
  parameter int DATA_W = 32,
  parameter int ADDR_W = CH_SHIFT + $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_CH-1:0][PRE_W-1:0]  pre_o,
  output logic [NUM_CH-1:0][MOD_W-1:0]  stage_mod_o,
  output logic [NUM_CH-1:0]             commit_o,
  output logic [DUTY_W-1:0]             commit_duty_o,
  output logic [NUM_CH-1:0]             en_o
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0]   ch_idx;
  logic [WORD_W-1:0] word_idx;
  logic              mapped;
  logic [NUM_CH-1:0][DATA_W-1:0] rd_vec;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  assign ch_idx   = addr[CH_SHIFT +: CH_W];
  assign word_idx = addr[CH_SHIFT-1:2];
  assign mapped   = (word_idx == WORD_PRE) || (word_idx == WORD_MOD) ||
                    (word_idx == WORD_DUTY) || (word_idx == WORD_EN);
  assign commit_duty_o = wdata[DUTY_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              hit;
    logic              pre_we, mod_we, duty_we, en_we;
    logic [PRE_W-1:0]  pre_q;
    logic [MOD_W-1:0]  mod_q;
    logic [DUTY_W-1:0] duty_q;
    logic              en_q;
    logic [DATA_W-1:0] rd_word;

    assign hit     = (ch_idx == CH_W'(c));
    assign pre_we  = wr_en & hit & (word_idx == WORD_PRE);
    assign mod_we  = wr_en & hit & (word_idx == WORD_MOD);
    assign duty_we = wr_en & hit & (word_idx == WORD_DUTY);
    assign en_we   = wr_en & hit & (word_idx == WORD_EN);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_q  <= '0;
        mod_q  <= '0;
        duty_q <= '0;
        en_q   <= 1'b0;
      end else begin
        if (pre_we)  pre_q  <= wdata[PRE_W-1:0];
        if (mod_we)  mod_q  <= wdata[MOD_W-1:0];
        if (duty_we) duty_q <= wdata[DUTY_W-1:0];
        if (en_we)   en_q   <= wdata[0];
      end
    end

    always_comb begin
      rd_word = '0;
      if (word_idx == WORD_PRE)       rd_word = {{(DATA_W-PRE_W){1'b0}}, pre_q};
      else if (word_idx == WORD_MOD)  rd_word = {{(DATA_W-MOD_W){1'b0}}, mod_q};
      else if (word_idx == WORD_DUTY) rd_word = {{(DATA_W-DUTY_W){1'b0}}, duty_q};
      else if (word_idx == WORD_EN)   rd_word = {{(DATA_W-1){1'b0}}, en_q};
    end

    assign rd_vec[c]      = rd_word;
    assign pre_o[c]       = pre_q;
    assign stage_mod_o[c] = mod_q;
    assign commit_o[c]    = duty_we;
    assign en_o[c]        = en_q;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_vec[ch_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R9: holes in the window read back as zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata_o == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [MOD_W-1:0]  stage_mod_i,
  input  logic              commit_i,
  input  logic [DUTY_W-1:0] commit_duty_i,
  output logic              pwm_o
);
  logic [PRE_W-1:0]  pcnt_q, pcnt_d, act_pre_q, act_pre_d;
  logic [MOD_W-1:0]  cnt_q, cnt_d, act_mod_q, act_mod_d, pend_mod_q, pend_mod_d;
  logic [DUTY_W-1:0] act_duty_q, act_duty_d, pend_duty_q, pend_duty_d;
  logic              pend_q, pend_d;
  logic              step, last, boundary;
  logic [MOD_W:0]    cnt_inc;

  assign step     = (pcnt_q == act_pre_q);
  assign cnt_inc  = {1'b0, cnt_q} + (MOD_W+1)'(1);
  assign last     = (cnt_inc >= {1'b0, act_mod_q});
  assign boundary = en_i & step & last;

  always_comb begin
    pcnt_d      = pcnt_q;
    cnt_d       = cnt_q;
    act_pre_d   = act_pre_q;
    act_mod_d   = act_mod_q;
    act_duty_d  = act_duty_q;
    pend_d      = pend_q;
    pend_mod_d  = pend_mod_q;
    pend_duty_d = pend_duty_q;
    if (!en_i || boundary) begin
      pcnt_d    = '0;
      cnt_d     = '0;
      act_pre_d = pre_i;
      pend_d    = 1'b0;
      if (commit_i) begin
        act_mod_d  = stage_mod_i;
        act_duty_d = commit_duty_i;
      end else if (pend_q) begin
        act_mod_d  = pend_mod_q;
        act_duty_d = pend_duty_q;
      end
    end else begin
      if (step) begin
        pcnt_d = '0;
        cnt_d  = cnt_q + MOD_W'(1);
      end else begin
        pcnt_d = pcnt_q + PRE_W'(1);
      end
      if (commit_i) begin
        pend_d      = 1'b1;
        pend_mod_d  = stage_mod_i;
        pend_duty_d = commit_duty_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q      <= '0;
      cnt_q       <= '0;
      act_pre_q   <= '0;
      act_mod_q   <= '0;
      act_duty_q  <= '0;
      pend_q      <= 1'b0;
      pend_mod_q  <= '0;
      pend_duty_q <= '0;
    end else begin
      pcnt_q      <= pcnt_d;
      cnt_q       <= cnt_d;
      act_pre_q   <= act_pre_d;
      act_mod_q   <= act_mod_d;
      act_duty_q  <= act_duty_d;
      pend_q      <= pend_d;
      pend_mod_q  <= pend_mod_d;
      pend_duty_q <= pend_duty_d;
    end
  end

  assign pwm_o = en_i & (DUTY_W'(cnt_q) < act_duty_q);

  // R3: prescale counter never passes the active prescale value
  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= act_pre_q);
  // R4: period count stays inside the active modulus
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || (cnt_q < act_mod_q));
  // R6: active settings move only at a boundary or while halted
  p_settings_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !boundary) |=> ($stable(act_mod_q) && $stable(act_duty_q)));
  // R11: prescale is resampled only at a boundary or while halted
  p_prescale_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !boundary) |=> $stable(act_pre_q));
  // R7: one edge after enable drops, both counters are back at zero
  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_i) |=> (cnt_q == '0 && pcnt_q == '0));
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PRE_W  = DEF_PRE_W,
  parameter int MOD_W  = DEF_MOD_W,
  parameter int DUTY_W = DEF_DUTY_W,
  parameter int DATA_W = 32,
  localparam int ADDR_W = CH_SHIFT + $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0][PRE_W-1:0] pre_v;
  logic [NUM_CH-1:0][MOD_W-1:0] mod_v;
  logic [NUM_CH-1:0]            commit_v;
  logic [NUM_CH-1:0]            en_v;
  logic [DUTY_W-1:0]            duty_bus;

  pwm_regbank #(
    .NUM_CH(NUM_CH), .PRE_W(PRE_W), .MOD_W(MOD_W),
    .DUTY_W(DUTY_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata_o(rdata),
    .pre_o(pre_v), .stage_mod_o(mod_v), .commit_o(commit_v),
    .commit_duty_o(duty_bus), .en_o(en_v)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pwm
    pwm_chan #(.PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .en_i(en_v[c]), .pre_i(pre_v[c]),
      .stage_mod_i(mod_v[c]), .commit_i(commit_v[c]),
      .commit_duty_i(duty_bus), .pwm_o(pwm_out[c])
    );
  end
endmodule

// File: tb/pwm_shadow_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_shadow_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;

  pwm_shadow_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R12 reset";

  // reference model state
  int m_pre[4], m_mod[4], m_duty[4], m_en[4];
  int a_pre[4], a_mod[4], a_duty[4];
  int pend[4], p_mod[4], p_duty[4], pcnt[4], cnt[4];
  int m_rdata;
  int mch, mw;
  bit mcommit;
  logic [3:0] exp_pwm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_pre[c] = 0; m_mod[c] = 0; m_duty[c] = 0; m_en[c] = 0;
        a_pre[c] = 0; a_mod[c] = 0; a_duty[c] = 0;
        pend[c] = 0; p_mod[c] = 0; p_duty[c] = 0; pcnt[c] = 0; cnt[c] = 0;
      end
      m_rdata = 0;
    end else begin
      mch = int'(addr[6:5]);
      mw  = int'(addr[4:2]);
      if (rd_en) begin
        case (mw)
          0: m_rdata = m_pre[mch];
          1: m_rdata = m_mod[mch];
          2: m_rdata = m_duty[mch];
          6: m_rdata = m_en[mch];
          default: m_rdata = 0;
        endcase
      end
      for (int c = 0; c < 4; c++) begin
        mcommit = wr_en && (mch == c) && (mw == 2);
        if (m_en[c] == 0 ||
            (pcnt[c] == a_pre[c] && cnt[c] + 1 >= a_mod[c])) begin
          pcnt[c] = 0; cnt[c] = 0; a_pre[c] = m_pre[c];
          if (mcommit) begin a_mod[c] = m_mod[c]; a_duty[c] = int'(wdata[15:0]); end
          else if (pend[c] != 0) begin a_mod[c] = p_mod[c]; a_duty[c] = p_duty[c]; end
          pend[c] = 0;
        end else begin
          if (pcnt[c] == a_pre[c]) begin pcnt[c] = 0; cnt[c]++; end
          else pcnt[c]++;
          if (mcommit) begin pend[c] = 1; p_mod[c] = m_mod[c]; p_duty[c] = int'(wdata[15:0]); end
        end
      end
      if (wr_en) begin
        case (mw)
          0: m_pre[mch]  = int'(wdata[7:0]);
          1: m_mod[mch]  = int'(wdata[7:0]);
          2: m_duty[mch] = int'(wdata[15:0]);
          6: m_en[mch]   = int'(wdata[0]);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 4; c++)
        exp_pwm[c] = (m_en[c] != 0) && (cnt[c] < a_duty[c]);
      checks++;
      if (pwm_out !== exp_pwm) begin
        errors++;
        $display("FAIL %s: pwm_out=%b expected %b at %0t", phase, pwm_out, exp_pwm, $time);
      end
      checks++;
      if (rdata !== 32'(m_rdata)) begin
        errors++;
        $display("FAIL %s: rdata=%h expected %h at %0t", phase, rdata, 32'(m_rdata), $time);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input int ofs, input int val);
    @(negedge clk);
    wr_en = 1'b1; addr = 7'((ch << 5) | ofs); wdata = 32'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int ofs);
    @(negedge clk);
    rd_en = 1'b1; addr = 7'((ch << 5) | ofs);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_all(input int ch);
    for (int o = 0; o < 32; o += 4) rd(ch, o);
  endtask

  task automatic finish_run;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL %s: watchdog expired, actual running expected finished", phase);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    phase = "R12 reset state";
    idle(3);
    read_all(0);

    phase = "R3/R4/R5 prescaled waveform";
    wr(0, 'h0, 2); wr(0, 'h4, 5); wr(0, 'h8, 2); wr(0, 'h18, 1);
    idle(60);

    phase = "R1/R2 readback";
    read_all(0);
    rd(0, 'h9); rd(0, 'h1A);
    wr(0, 'h1, 1); // addr[1:0] ignored: prescale becomes 1
    rd(0, 'h0);
    idle(4);

    phase = "R6 staged modulus without duty";
    wr(0, 'h4, 8);
    idle(40);
    phase = "R6 commit mid-period";
    idle(3);
    wr(0, 'h8, 6);
    idle(40);

    phase = "R5 duty at or above modulus";
    wr(0, 'h8, 10);
    idle(40);
    phase = "R5 duty zero";
    wr(0, 'h8, 0);
    idle(30);

    phase = "R6 commit swept across boundary";
    wr(0, 'h0, 2); wr(0, 'h4, 4);
    for (int d = 0; d < 14; d++) begin
      wr(0, 'h8, (d % 5));
      idle(d);
    end
    idle(20);

    phase = "R7 disable mid-period";
    wr(0, 'h8, 3);
    idle(7);
    wr(0, 'h18, 0);
    idle(10);
    phase = "R7 commit pending at disable";
    wr(0, 'h18, 1);
    idle(4);
    wr(0, 'h4, 6); wr(0, 'h8, 5); wr(0, 'h18, 0);
    idle(5);

    phase = "R8 commit while disabled then enable";
    wr(0, 'h4, 3); wr(0, 'h8, 1);
    idle(5);
    wr(0, 'h18, 1);
    idle(30);
    rd(0, 'h18);

    phase = "R9 unmapped offsets";
    wr(0, 'hC, 'hFF); wr(0, 'h10, 'hFF); wr(0, 'h14, 'hFF); wr(0, 'h1C, 'hFF);
    rd(0, 'hC); rd(0, 'h10); rd(0, 'h14); rd(0, 'h1C);
    idle(10);

    phase = "R10 independent channels";
    wr(1, 'h0, 0); wr(1, 'h4, 3); wr(1, 'h8, 1); wr(1, 'h18, 1);
    wr(2, 'h0, 1); wr(2, 'h4, 7); wr(2, 'h8, 4); wr(2, 'h18, 1);
    wr(3, 'h0, 3); wr(3, 'h4, 2); wr(3, 'h8, 1); wr(3, 'h18, 1);
    idle(40);
    wr(2, 'h18, 0);
    idle(20);
    read_all(1); read_all(2); read_all(3);

    phase = "R11 prescale change while running";
    wr(1, 'h0, 4);
    idle(40);
    wr(3, 'h0, 0);
    idle(30);

    phase = "R4 modulus zero";
    wr(1, 'h0, 1); wr(1, 'h4, 0); wr(1, 'h8, 0);
    idle(12);
    wr(1, 'h8, 1);
    idle(12);

    phase = "R12 reset again";
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
    read_all(2);

    finish_run();
  end
endmodule